// File: doc/BRIEF.md
# Latched Interrupt Controller with Acknowledge Sequencer

This block sits beside the fetch and execute path of a small 4-bit processor core and decides when an interrupt is taken. Each source has its own request latch. A latch is set by a one-cycle request pulse and stays set until the source is taken or software clears it. A latched source may be taken when three things hold: the master enable flag is set, the source's bit in the per-source enable register is set, and the core reports an instruction boundary. One designated source (index `BYP_IDX`) ignores the per-source enable register, so software can only hold it off with the master enable or its own flag in memory.

The core reports an instruction boundary with `insn_done_i`. If `tmr_busy_i` is high at that point, the boundary is remembered and the block waits until the timer/counter work has finished. When a source is taken, a fixed two-cycle sequence runs. The current program counter and flags are pushed onto an internal stack of 4 entries. The master enable is dropped and the taken latch is cleared. After that, the source's vector is presented together with a load strobe, and the status flag is set. `ack_busy_o` stalls fetch for the whole sequence.

A return operation pops the stack, presents the saved program counter and flags with their own load strobe, and sets the master enable again. A combined operation writes the master enable and clears the latches picked by a mask in one cycle. Software uses it to allow nested interrupts from inside a handler.

Top module: `lic_top`

## Requirements
- R1: A request pulse on `irq_i[i]` sets `pend_o[i]` one cycle later. The bit then stays set until source i is taken or a combined operation clears it. If a request arrives in the same cycle as a clear of the same latch, the latch stays set.
- R2: When `ctl_wr_i` is high, `ien_o` takes the value of `ctl_ien_i` on the next cycle. Each latch whose `ctl_keep_i` bit is 0 is cleared, and each latch whose bit is 1 keeps its value.
- R3: A latched source is taken only when `ien_o` is 1 and its bit in the per-source enable register (loaded from `en_i` when `en_wr_i` is high, reset value 0) is 1. Source `BYP_IDX` (default 1) is taken regardless of that register.
- R4: When several eligible sources are pending, the lowest index wins. `vec_o` equals `VEC_BASE` + 2 × index, which is 0x020 + 2×index by default. The sources that lose stay pending.
- R5: A source can be taken only in a cycle where `insn_done_i` is high, or where a boundary was seen earlier while `tmr_busy_i` was high. In both cases `tmr_busy_i` must be low in that cycle. `ack_busy_o` is then high for exactly two cycles, and `vec_ld_o` is high in the second of them.
- R6: When a source is taken, the next cycle shows `ien_o` = 0 and that source's latch cleared, and `{pc_i, flags_i}` from the taking cycle is pushed. `sf_o` becomes 1 in the cycle `vec_ld_o` is high.
- R7: A `reti_i` pulse while `ack_busy_o` is low pops the stack. On the next cycle `ret_ld_o` is high, `ret_pc_o`/`ret_flags_o` hold the popped values, `ien_o` is 1, and `sf_o` equals bit `SF_BIT` (default 0) of the popped flags. A `reti_i` while `ack_busy_o` is high is ignored. A source cannot be taken in the same cycle as a return.
- R8: The stack holds 4 entries and pops in LIFO order. A fifth push overwrites the oldest entry. A pop of an empty stack produces no `ret_ld_o`. Both of these events set `stk_err_o`, which stays set until reset.
- R9: If a handler sets `ien_o` again through the combined operation, a further eligible request is taken at the next boundary. The two returns then restore the inner context first and the outer context second.
- R10: After reset `pend_o`, `ien_o`, `ack_busy_o`, `vec_ld_o`, `ret_ld_o`, `sf_o` and `stk_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | One-cycle request pulses, one per source |
| en_wr_i | input | 1 | Load the per-source enable register |
| en_i | input | N_SRC | New per-source enable value |
| ctl_wr_i | input | 1 | Combined master-enable write and latch clear |
| ctl_ien_i | input | 1 | Master enable value for the combined operation |
| ctl_keep_i | input | N_SRC | Clear mask: 0 clears the latch, 1 keeps it |
| insn_done_i | input | 1 | Current instruction has completed |
| tmr_busy_i | input | 1 | Timer/counter processing still in progress |
| reti_i | input | 1 | Return-from-interrupt operation |
| pc_i | input | PC_W | Program counter to save |
| flags_i | input | FL_W | Flags to save |
| ack_busy_o | output | 1 | Acknowledge sequence running; stalls fetch |
| vec_ld_o | output | 1 | Load `vec_o` into the program counter |
| vec_o | output | PC_W | Vector address of the taken source |
| ret_ld_o | output | 1 | Load the restored program counter and flags |
| ret_pc_o | output | PC_W | Popped program counter |
| ret_flags_o | output | FL_W | Popped flags |
| ien_o | output | 1 | Master enable flag |
| sf_o | output | 1 | Status flag |
| pend_o | output | N_SRC | Request latches |
| stk_err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
The bench puts a request and a clear on the same latch in the same cycle. A design that lets the clear win would lose that request. It pends a source the enable register blocks next to the bypass source, and it raises two requests together. A wrong gate or a reversed priority would give the wrong vector or take the blocked source. It holds a boundary while the timer is busy and sends a return during the acknowledge sequence. A sequencer that does not wait, or that accepts the return, would start too early or set the master enable again. Five nested entries followed by five returns test overwrite-oldest, LIFO order and the sticky error. A stack with an off-by-one pointer would return the wrong program counters.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK1 = 2'd1,
    SEQ_ACK2 = 2'd2
  } seq_t;
endpackage

// File: rtl/lic_latch.sv
module lic_latch #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] lat_o
);
  // a new request wins over either kind of clear
  for (genvar g = 0; g < N_SRC; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) lat_o[g] <= 1'b0;
      else     lat_o[g] <= set_i[g] | (lat_o[g] & ~sw_clr_i[g] & ~ack_clr_i[g]);
    end
  end

  a_r6_ack_clr_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_clr_i));
endmodule

// File: rtl/lic_arb.sv
module lic_arb #(
  parameter int          N_SRC    = 4,
  parameter int          PC_W     = 12,
  parameter logic [11:0] VEC_BASE = 12'h020
) (
  input  logic [N_SRC-1:0] elig_i,
  output logic             any_o,
  output logic [N_SRC-1:0] win_o,
  output logic [PC_W-1:0]  vec_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    win_o = '0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        win_o  = '0;
        win_o[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end

  assign any_o = |elig_i;
  assign vec_o = PC_W'(VEC_BASE) + (PC_W'(idx) << 1);
endmodule

// File: rtl/lic_stack.sv
module lic_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic         empty_o,
  output logic [W-1:0] top_o,
  output logic [W-1:0] dout_o,
  output logic         dout_vld_o,
  output logic         err_o
);
  localparam int SP_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [CNT_W-1:0] cnt;
  logic [SP_W-1:0]  sp_top;

  assign sp_top  = sp - SP_W'(1);
  assign empty_o = (cnt == '0);
  assign top_o   = mem[sp_top];

  // storage without reset so it maps onto distributed or block memory
  always_ff @(posedge clk) begin
    if (push_i) mem[sp] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp         <= '0;
      cnt        <= '0;
      err_o      <= 1'b0;
      dout_vld_o <= 1'b0;
      dout_o     <= '0;
    end else begin
      dout_vld_o <= 1'b0;
      if (push_i) begin
        sp <= sp + SP_W'(1);
        if (cnt == CNT_W'(DEPTH)) err_o <= 1'b1;
        else                      cnt   <= cnt + CNT_W'(1);
      end else if (pop_i) begin
        if (empty_o) begin
          err_o <= 1'b1;
        end else begin
          sp         <= sp_top;
          cnt        <= cnt - CNT_W'(1);
          dout_o     <= top_o;
          dout_vld_o <= 1'b1;
        end
      end
    end
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: rtl/lic_top.sv
module lic_top
  import lic_pkg::*;
#(
  parameter int          N_SRC    = 4,
  parameter int          PC_W     = 12,
  parameter int          FL_W     = 4,
  parameter int          DEPTH    = 4,
  parameter int          BYP_IDX  = 1,
  parameter int          SF_BIT   = 0,
  parameter logic [11:0] VEC_BASE = 12'h020
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             en_wr_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             ctl_wr_i,
  input  logic             ctl_ien_i,
  input  logic [N_SRC-1:0] ctl_keep_i,
  input  logic             insn_done_i,
  input  logic             tmr_busy_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [FL_W-1:0]  flags_i,
  output logic             ack_busy_o,
  output logic             vec_ld_o,
  output logic [PC_W-1:0]  vec_o,
  output logic             ret_ld_o,
  output logic [PC_W-1:0]  ret_pc_o,
  output logic [FL_W-1:0]  ret_flags_o,
  output logic             ien_o,
  output logic             sf_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             stk_err_o
);
  localparam int              CTX_W    = PC_W + FL_W;
  localparam logic [N_SRC-1:0] BYP_MASK = N_SRC'(1) << BYP_IDX;

  seq_t             state;
  logic [N_SRC-1:0] en_q;
  logic             bnd_q;
  logic [N_SRC-1:0] elig, win, ack_clr, sw_clr;
  logic             any, accept, idle, ret_go;
  logic [PC_W-1:0]  vec_nx;
  logic             stk_empty;
  logic [CTX_W-1:0] stk_top, stk_dout;

  assign idle    = (state == SEQ_IDLE);
  assign ret_go  = idle & reti_i;
  assign elig    = pend_o & (en_q | BYP_MASK);
  assign accept  = idle & ~reti_i & ien_o & any & ~tmr_busy_i & (insn_done_i | bnd_q);
  assign ack_clr = accept ? win : '0;
  assign sw_clr  = ctl_wr_i ? ~ctl_keep_i : '0;

  lic_latch #(.N_SRC(N_SRC)) u_latch (
    .clk(clk), .rst(rst), .set_i(irq_i), .sw_clr_i(sw_clr),
    .ack_clr_i(ack_clr), .lat_o(pend_o)
  );

  lic_arb #(.N_SRC(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE)) u_arb (
    .elig_i(elig), .any_o(any), .win_o(win), .vec_o(vec_nx)
  );

  lic_stack #(.DEPTH(DEPTH), .W(CTX_W)) u_stack (
    .clk(clk), .rst(rst), .push_i(accept), .pop_i(ret_go),
    .din_i({pc_i, flags_i}), .empty_o(stk_empty), .top_o(stk_top),
    .dout_o(stk_dout), .dout_vld_o(ret_ld_o), .err_o(stk_err_o)
  );

  assign ret_pc_o    = stk_dout[CTX_W-1:FL_W];
  assign ret_flags_o = stk_dout[FL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      en_q       <= '0;
      bnd_q      <= 1'b0;
      ien_o      <= 1'b0;
      sf_o       <= 1'b0;
      ack_busy_o <= 1'b0;
      vec_ld_o   <= 1'b0;
      vec_o      <= '0;
    end else begin
      if (en_wr_i) en_q <= en_i;
      bnd_q <= (insn_done_i | bnd_q) & tmr_busy_i;

      if (accept)          ien_o <= 1'b0;
      else if (ret_go)     ien_o <= 1'b1;
      else if (ctl_wr_i)   ien_o <= ctl_ien_i;

      vec_ld_o <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            state      <= SEQ_ACK1;
            ack_busy_o <= 1'b1;
            vec_o      <= vec_nx;
          end else if (ret_go && !stk_empty) begin
            sf_o <= stk_top[SF_BIT];
          end
        end
        SEQ_ACK1: begin
          state    <= SEQ_ACK2;
          vec_ld_o <= 1'b1;
          sf_o     <= 1'b1;
        end
        default: begin
          state      <= SEQ_IDLE;
          ack_busy_o <= 1'b0;
        end
      endcase
    end
  end

  a_r5_busy_two: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_busy_o) |=> (ack_busy_o && vec_ld_o));
  a_r5_busy_end: assert property (@(posedge clk) disable iff (rst)
    vec_ld_o |=> !ack_busy_o);
  a_r6_ien_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_busy_o) |-> (!ien_o && $past(ien_o)));
  a_r7_ret_cause: assert property (@(posedge clk) disable iff (rst)
    ret_ld_o |-> ($past(reti_i) && ien_o));
  a_r5_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_busy_o) |-> !$past(tmr_busy_i));
endmodule

// File: tb/lic_top_tb_top.sv
module lic_top_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_i = '0, en_i = '0, ctl_keep_i = '1;
  logic en_wr_i = 0, ctl_wr_i = 0, ctl_ien_i = 0, insn_done_i = 0, tmr_busy_i = 0, reti_i = 0;
  logic [11:0] pc_i = '0;
  logic [3:0]  flags_i = '0;
  logic ack_busy_o, vec_ld_o, ret_ld_o, ien_o, sf_o, stk_err_o;
  logic [11:0] vec_o, ret_pc_o;
  logic [3:0]  ret_flags_o;
  logic [N-1:0] pend_o;

  always #10 clk = ~clk;

  lic_top dut_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .en_wr_i(en_wr_i), .en_i(en_i),
    .ctl_wr_i(ctl_wr_i), .ctl_ien_i(ctl_ien_i), .ctl_keep_i(ctl_keep_i),
    .insn_done_i(insn_done_i), .tmr_busy_i(tmr_busy_i), .reti_i(reti_i),
    .pc_i(pc_i), .flags_i(flags_i), .ack_busy_o(ack_busy_o), .vec_ld_o(vec_ld_o),
    .vec_o(vec_o), .ret_ld_o(ret_ld_o), .ret_pc_o(ret_pc_o), .ret_flags_o(ret_flags_o),
    .ien_o(ien_o), .sf_o(sf_o), .pend_o(pend_o), .stk_err_o(stk_err_o)
  );

  int total = 0, bad = 0, cyc_cnt = 0;
  bit done_flag = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_state, m_ien, m_bnd, m_busy, m_vld, m_vec, m_rld, m_rpc, m_rfl, m_sf, m_err;
  bit [N-1:0] m_lat, m_en;
  int m_stk[$];

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_ien = 0; m_bnd = 0; m_busy = 0; m_vld = 0; m_vec = 0;
      m_rld = 0; m_rpc = 0; m_rfl = 0; m_sf = 0; m_err = 0; m_lat = '0; m_en = '0;
      m_stk.delete();
    end else begin
      automatic bit idle = (m_state == 0);
      automatic bit [N-1:0] el = m_lat & (m_en | 4'b0010);
      automatic int win = -1;
      automatic bit acc;
      automatic bit [N-1:0] nl;
      for (int i = 0; i < N; i++) if (el[i] && win < 0) win = i;
      acc = idle && !reti_i && m_ien != 0 && win >= 0 && !tmr_busy_i && (insn_done_i || m_bnd != 0);
      for (int i = 0; i < N; i++)
        nl[i] = irq_i[i] | (m_lat[i] & !(ctl_wr_i & !ctl_keep_i[i]) & !(acc && win == i));
      m_lat = nl;
      if (en_wr_i) m_en = en_i;
      m_bnd = (insn_done_i || m_bnd != 0) && tmr_busy_i;
      m_rld = 0; m_vld = 0;
      if (acc) m_ien = 0;
      else if (idle && reti_i) m_ien = 1;
      else if (ctl_wr_i) m_ien = ctl_ien_i;
      if (acc) begin
        m_stk.push_back({pc_i, flags_i});
        if (m_stk.size() > 4) begin void'(m_stk.pop_front()); m_err = 1; end
        m_vec = 'h020 + 2 * win; m_state = 1; m_busy = 1;
      end else if (m_state == 1) begin
        m_state = 2; m_vld = 1; m_sf = 1;
      end else if (m_state == 2) begin
        m_state = 0; m_busy = 0;
      end else if (reti_i) begin
        if (m_stk.size() == 0) m_err = 1;
        else begin
          automatic int v = m_stk.pop_back();
          m_rpc = v >> 4; m_rfl = v & 'hf; m_rld = 1; m_sf = v & 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R5 busy", ack_busy_o, m_busy);
      chk("R5 vec_ld", vec_ld_o, m_vld);
      if (m_vld) chk("R4 vector", vec_o, m_vec);
      chk("R1 pend", pend_o, m_lat);
      chk("R6 ien", ien_o, m_ien);
      chk("R6 sf", sf_o, m_sf);
      chk("R7 ret_ld", ret_ld_o, m_rld);
      if (m_rld) begin
        chk("R7 ret_pc", ret_pc_o, m_rpc);
        chk("R7 ret_flags", ret_flags_o, m_rfl);
      end
      chk("R8 err", stk_err_o, m_err);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq(logic [N-1:0] m);
    irq_i = m; cyc(1); irq_i = '0;
  endtask

  task automatic boundary(int pc, int fl);
    pc_i = 12'(pc); flags_i = 4'(fl); insn_done_i = 1; cyc(1); insn_done_i = 0;
  endtask

  task automatic ctl(bit ien, logic [N-1:0] keep);
    ctl_wr_i = 1; ctl_ien_i = ien; ctl_keep_i = keep; cyc(1); ctl_wr_i = 0; ctl_keep_i = '1;
  endtask

  task automatic ret();
    reti_i = 1; cyc(1); reti_i = 0;
  endtask

  task automatic expect_vec(string req, int exp);
    for (int k = 0; k < 8; k++) begin
      if (vec_ld_o) begin chk(req, vec_o, exp); return; end
      cyc(1);
    end
    chk(req, 0, exp);
  endtask

  task automatic expect_ret(string req, int exp);
    for (int k = 0; k < 4; k++) begin
      if (ret_ld_o) begin chk(req, ret_pc_o, exp); return; end
      cyc(1);
    end
    chk(req, 0, exp);
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    chk("R10 pend", pend_o, 0);   chk("R10 ien", ien_o, 0);
    chk("R10 busy", ack_busy_o, 0); chk("R10 err", stk_err_o, 0); chk("R10 sf", sf_o, 0);

    pulse_irq(4'b0100); cyc(3);
    chk("R1 held", pend_o, 4'b0100);
    irq_i = 4'b1000; ctl(0, 4'b0011); irq_i = '0;
    chk("R1 req beats clear / R2 clear", pend_o, 4'b1000);
    chk("R2 ien write 0", ien_o, 0);
    ctl(1, 4'b1111);
    chk("R2 ien write 1", ien_o, 1);
    chk("R2 keep", pend_o, 4'b1000);

    boundary('h100, 'h6); cyc(3);
    chk("R3 blocked by enable reg", ack_busy_o, 0);
    pulse_irq(4'b0010); boundary('h101, 'h6);
    expect_vec("R3 bypass source", 'h022);
    cyc(1); chk("R6 latch cleared", pend_o, 4'b1000);
    ret(); expect_ret("R7 return pc", 'h101);
    chk("R7 ien rearmed", ien_o, 1); chk("R7 sf from flags", sf_o, 0);

    en_wr_i = 1; en_i = 4'b1111; cyc(1); en_wr_i = 0;
    pulse_irq(4'b0101); boundary('h110, 'h1);
    expect_vec("R4 lowest wins", 'h020);
    cyc(1); chk("R4 losers kept", pend_o, 4'b1100);
    ret(); cyc(1); boundary('h111, 0); expect_vec("R4 next", 'h024);
    cyc(1); ret(); cyc(1); boundary('h112, 0); expect_vec("R4 last", 'h026);
    cyc(1); ret(); cyc(1);

    pulse_irq(4'b0001); tmr_busy_i = 1; boundary('h120, 0); cyc(3);
    chk("R5 waits for timer", ack_busy_o, 0);
    tmr_busy_i = 0;
    expect_vec("R5 after timer", 'h020);
    cyc(1); ret(); cyc(1);

    pulse_irq(4'b0100); boundary('h130, 'h3); expect_vec("R9 outer", 'h024);
    cyc(1); ctl(1, 4'b1111);
    pulse_irq(4'b0001); boundary('h140, 'h2); expect_vec("R9 inner", 'h020);
    cyc(1); ret(); expect_ret("R9 inner return", 'h140);
    chk("R7 sf restored", sf_o, 0);
    cyc(1); ret(); expect_ret("R9 outer return", 'h130);
    chk("R7 sf restored 1", sf_o, 1);

    pulse_irq(4'b1000); boundary('h150, 0); reti_i = 1; cyc(1); reti_i = 0;
    expect_vec("R7 reti during busy", 'h026);
    cyc(1); chk("R7 reti ignored while busy", ien_o, 0);
    ret(); expect_ret("R7 return", 'h150);

    for (int k = 1; k <= 5; k++) begin
      pulse_irq(4'b0001); boundary('h200 + k, 0); expect_vec("R8 push", 'h020);
      cyc(1); ctl(1, 4'b1111);
    end
    chk("R8 overflow err", stk_err_o, 1);
    for (int k = 5; k >= 2; k--) begin
      ret(); expect_ret("R8 lifo", 'h200 + k); cyc(1);
    end
    ret(); cyc(2);
    chk("R8 empty pop no load", ret_ld_o, 0);
    chk("R8 err sticky", stk_err_o, 1);

    cyc(2);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done_flag) begin
      done_flag = 1; total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc_cnt);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule